// File: doc/BRIEF.md
# RC4 Stream Decryption Core

The core recovers a short plaintext message from ciphertext using the RC4 stream cipher with a 3-byte secret key. It holds three memories: a 256-entry byte permutation table, a 32-byte ciphertext store, and a 32-byte plaintext store. Each memory is a single-port synchronous array whose read data appears one cycle after the address. When a start pulse is accepted, a phase scheduler runs three sequential phases. The first fills the table with the identity permutation. The second mixes the table under the key, with one swap for each entry. The third produces 32 keystream bytes and XORs each one with the matching ciphertext byte.

Ciphertext is written into the store through a byte-wide load port while the core is idle. Plaintext is read back through a byte-wide read port. A single-cycle completion pulse marks the end of a run. A full run takes a fixed number of cycles, independent of the key and the data.

Top module: `rc4_decrypt_core`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: Every run starts from the identity table: running with a key gives the same plaintext whatever ran before it.
- R3: Key byte 0 (used when the table index mod 3 is 0) is `key[23:16]`, byte 1 is `key[15:8]`, byte 2 is `key[7:0]`. The mixing phase computes j = (j + s[i] + keybyte[i mod 3]) mod 256 and swaps s[i] and s[j], for i = 0..255.
- R4: For k = 0..31 the generation phase steps i = i+1, then j = j+s[i], then swaps, then f = s[(s[i]+s[j]) mod 256]. It stores `f XOR ct[k]` at plaintext address k, where ct[k] is the byte loaded at ciphertext address k.
- R5: `done` is high for exactly one cycle per run. It is high in the cycle after the 2048th rising edge that follows the edge which sampled the accepted start.
- R6: A `start` pulse while `busy` is high is ignored: the run neither restarts nor lengthens, and exactly one `done` follows.
- R7: A ciphertext load while `busy` is high does not change the stored ciphertext.
- R8: `ptRdData` shows the plaintext byte at `ptRdAddr` one cycle after the address is presented, and the bytes stay readable after the run.
- R9: `busy` rises in the cycle after an accepted start, stays high until `done`, and is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| key | input | 24 | Secret key, byte 0 in the top 8 bits |
| ctLoadEn | input | 1 | Write strobe for the ciphertext store |
| ctLoadAddr | input | 5 | Ciphertext byte address |
| ctLoadData | input | 8 | Ciphertext byte to store |
| ptRdAddr | input | 5 | Plaintext byte address for readout |
| ptRdData | output | 8 | Plaintext byte, one cycle after its address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Single-cycle end-of-run pulse |

## Verification
The checker watches the handshake on every cycle: how long the done pulse lasts, when busy rises after an accepted start, that busy holds through a run regardless of extra starts, and that busy drops only right after done. The bench scenarios are the only way to show the cipher arithmetic is correct. They compare every plaintext byte with an independent model of the cipher, over directed keys, seeded random keys and ciphertexts, and repeated keys. They also show that a start or a ciphertext load issued mid-run leaves the output unchanged.

// File: rtl/rc4_pkg.sv
package rc4_pkg;
  localparam int BYTE_W  = 8;
  localparam int TABLE_N = 1 << BYTE_W;

  typedef enum logic [1:0] {ADR_I, ADR_INEXT, ADR_J, ADR_SUM} addrSel_e;
  typedef enum logic [1:0] {WD_IDX, WD_SI, WD_SJ} wdSel_e;

  typedef enum logic [2:0] {PH_IDLE, PH_INIT, PH_MIX, PH_GEN, PH_DONE} phase_e;
  typedef enum logic [2:0] {M_RDI, M_CAPI, M_RDJ, M_CAPJ, M_WRI, M_WRJ} mixStep_e;
  typedef enum logic [2:0] {G_RDI, G_CAPI, G_RDJ, G_CAPJ, G_WRI, G_WRJ, G_RDF, G_XOR} genStep_e;

  typedef struct packed {
    logic     sWe;
    addrSel_e addrSel;
    wdSel_e   wdSel;
    logic     iClr;
    logic     iInc;
    logic     jClr;
    logic     jMix;
    logic     jGen;
    logic     siLoad;
    logic     sjLoad;
    logic     kClr;
    logic     kInc;
    logic     ptWe;
  } strobe_t;
endpackage

// File: rtl/rc4_spram.sv
module rc4_spram #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rc4_ctrl.sv
module rc4_ctrl
  import rc4_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    iLast,
  input  logic    kLast,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  phase_e   phase, phaseNxt;
  mixStep_e mixStep, mixNxt;
  genStep_e genStep, genNxt;
  logic initFin, mixFin, genFin;

  // scheduler: each phase starts when the previous one reports finished
  always_comb begin
    phaseNxt = phase;
    unique case (phase)
      PH_IDLE: if (start)   phaseNxt = PH_INIT;
      PH_INIT: if (initFin) phaseNxt = PH_MIX;
      PH_MIX:  if (mixFin)  phaseNxt = PH_GEN;
      PH_GEN:  if (genFin)  phaseNxt = PH_DONE;
      PH_DONE:              phaseNxt = PH_IDLE;
      default:              phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  // mixing phase step sequencer
  always_comb begin
    unique case (mixStep)
      M_RDI:   mixNxt = M_CAPI;
      M_CAPI:  mixNxt = M_RDJ;
      M_RDJ:   mixNxt = M_CAPJ;
      M_CAPJ:  mixNxt = M_WRI;
      M_WRI:   mixNxt = M_WRJ;
      default: mixNxt = M_RDI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || phase != PH_MIX) mixStep <= M_RDI;
    else                          mixStep <= mixNxt;
  end

  // generation phase step sequencer
  always_comb begin
    unique case (genStep)
      G_RDI:   genNxt = G_CAPI;
      G_CAPI:  genNxt = G_RDJ;
      G_RDJ:   genNxt = G_CAPJ;
      G_CAPJ:  genNxt = G_WRI;
      G_WRI:   genNxt = G_WRJ;
      G_WRJ:   genNxt = G_RDF;
      G_RDF:   genNxt = G_XOR;
      default: genNxt = G_RDI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || phase != PH_GEN) genStep <= G_RDI;
    else                          genStep <= genNxt;
  end

  // strobe decode
  always_comb begin
    strb    = '0;
    initFin = 1'b0;
    mixFin  = 1'b0;
    genFin  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          strb.iClr = 1'b1;
          strb.jClr = 1'b1;
          strb.kClr = 1'b1;
        end
      end
      PH_INIT: begin
        strb.sWe     = 1'b1;
        strb.addrSel = ADR_I;
        strb.wdSel   = WD_IDX;
        strb.iInc    = 1'b1;
        initFin      = iLast;
      end
      PH_MIX: begin
        unique case (mixStep)
          M_RDI:  strb.addrSel = ADR_I;
          M_CAPI: begin
            strb.siLoad = 1'b1;
            strb.jMix   = 1'b1;
          end
          M_RDJ:  strb.addrSel = ADR_J;
          M_CAPJ: strb.sjLoad  = 1'b1;
          M_WRI: begin
            strb.sWe     = 1'b1;
            strb.addrSel = ADR_I;
            strb.wdSel   = WD_SJ;
          end
          default: begin
            strb.sWe     = 1'b1;
            strb.addrSel = ADR_J;
            strb.wdSel   = WD_SI;
            strb.iInc    = 1'b1;
            if (iLast) begin
              mixFin    = 1'b1;
              strb.jClr = 1'b1;
            end
          end
        endcase
      end
      PH_GEN: begin
        unique case (genStep)
          G_RDI: begin
            strb.addrSel = ADR_INEXT;
            strb.iInc    = 1'b1;
          end
          G_CAPI: begin
            strb.siLoad = 1'b1;
            strb.jGen   = 1'b1;
          end
          G_RDJ:  strb.addrSel = ADR_J;
          G_CAPJ: strb.sjLoad  = 1'b1;
          G_WRI: begin
            strb.sWe     = 1'b1;
            strb.addrSel = ADR_I;
            strb.wdSel   = WD_SJ;
          end
          G_WRJ: begin
            strb.sWe     = 1'b1;
            strb.addrSel = ADR_J;
            strb.wdSel   = WD_SI;
          end
          G_RDF:  strb.addrSel = ADR_SUM;
          default: begin
            strb.ptWe = 1'b1;
            strb.kInc = 1'b1;
            genFin    = kLast;
          end
        endcase
      end
      default: ;
    endcase
  end

  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_DONE);
endmodule

// File: rtl/rc4_datapath.sv
module rc4_datapath
  import rc4_pkg::*;
#(
  parameter int KEY_BYTES = 3,
  parameter int MSG_LEN   = 32,
  localparam int KEY_W    = KEY_BYTES * BYTE_W,
  localparam int MSG_AW   = $clog2(MSG_LEN),
  localparam int KIDX_W   = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic [KEY_W-1:0]  key,
  input  logic              ctLoadEn,
  input  logic [MSG_AW-1:0] ctLoadAddr,
  input  logic [BYTE_W-1:0] ctLoadData,
  input  logic [MSG_AW-1:0] ptRdAddr,
  output logic [BYTE_W-1:0] ptRdData,
  output logic              iLast,
  output logic              kLast
);
  logic [BYTE_W-1:0] idxI, idxJ, valSi, valSj;
  logic [MSG_AW-1:0] idxK;
  logic [KIDX_W-1:0] kIdx;
  logic [BYTE_W-1:0] keyArr [KEY_BYTES];

  logic [BYTE_W-1:0] sAddr, sWdata, sRdata;
  logic              romWe;
  logic [MSG_AW-1:0] romAddr, ptAddr;
  logic [BYTE_W-1:0] romRdata, ptWdata;

  // key byte 0 sits in the most significant byte
  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_keyByte
    assign keyArr[g] = key[KEY_W-1-g*BYTE_W -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxI  <= '0;
      idxJ  <= '0;
      idxK  <= '0;
      kIdx  <= '0;
      valSi <= '0;
      valSj <= '0;
    end else begin
      if (strb.iClr)      idxI <= '0;
      else if (strb.iInc) idxI <= idxI + 1'b1;

      if (strb.jClr)      idxJ <= '0;
      else if (strb.jMix) idxJ <= idxJ + sRdata + keyArr[kIdx];
      else if (strb.jGen) idxJ <= idxJ + sRdata;

      if (strb.iClr) kIdx <= '0;
      else if (strb.jMix)
        kIdx <= (kIdx == KIDX_W'(KEY_BYTES-1)) ? '0 : kIdx + 1'b1;

      if (strb.kClr)      idxK <= '0;
      else if (strb.kInc) idxK <= idxK + 1'b1;

      if (strb.siLoad) valSi <= sRdata;
      if (strb.sjLoad) valSj <= sRdata;
    end
  end

  always_comb begin
    unique case (strb.addrSel)
      ADR_I:     sAddr = idxI;
      ADR_INEXT: sAddr = idxI + 1'b1;
      ADR_J:     sAddr = idxJ;
      default:   sAddr = valSi + valSj;
    endcase
    unique case (strb.wdSel)
      WD_IDX:  sWdata = idxI;
      WD_SI:   sWdata = valSi;
      default: sWdata = valSj;
    endcase
  end

  rc4_spram #(.DW(BYTE_W), .DEPTH(TABLE_N)) u_stateRam (
    .clk(clk), .we(strb.sWe), .addr(sAddr), .wdata(sWdata), .rdata(sRdata)
  );

  assign romWe   = ctLoadEn & ~busy;
  assign romAddr = busy ? idxK : ctLoadAddr;

  rc4_spram #(.DW(BYTE_W), .DEPTH(MSG_LEN)) u_ctRom (
    .clk(clk), .we(romWe), .addr(romAddr), .wdata(ctLoadData), .rdata(romRdata)
  );

  assign ptAddr  = strb.ptWe ? idxK : ptRdAddr;
  assign ptWdata = sRdata ^ romRdata;

  rc4_spram #(.DW(BYTE_W), .DEPTH(MSG_LEN)) u_ptRam (
    .clk(clk), .we(strb.ptWe), .addr(ptAddr), .wdata(ptWdata), .rdata(ptRdData)
  );

  assign iLast = (idxI == {BYTE_W{1'b1}});
  assign kLast = (idxK == MSG_AW'(MSG_LEN-1));
endmodule

// File: rtl/rc4_decrypt_core.sv
module rc4_decrypt_core
  import rc4_pkg::*;
#(
  parameter int KEY_BYTES = 3,
  parameter int MSG_LEN   = 32,
  localparam int KEY_W    = KEY_BYTES * BYTE_W,
  localparam int MSG_AW   = $clog2(MSG_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [KEY_W-1:0]  key,
  input  logic              ctLoadEn,
  input  logic [MSG_AW-1:0] ctLoadAddr,
  input  logic [BYTE_W-1:0] ctLoadData,
  input  logic [MSG_AW-1:0] ptRdAddr,
  output logic [BYTE_W-1:0] ptRdData,
  output logic              busy,
  output logic              done
);
  strobe_t strb;
  logic iLast, kLast;

  rc4_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .iLast(iLast), .kLast(kLast),
    .strb(strb), .busy(busy), .done(done)
  );

  rc4_datapath #(.KEY_BYTES(KEY_BYTES), .MSG_LEN(MSG_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .key(key),
    .ctLoadEn(ctLoadEn), .ctLoadAddr(ctLoadAddr), .ctLoadData(ctLoadData),
    .ptRdAddr(ptRdAddr), .ptRdData(ptRdData), .iLast(iLast), .kLast(kLast)
  );
endmodule

// File: rtl/rc4_decrypt_core_chk.sv
module rc4_decrypt_core_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R9
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));
endmodule

bind rc4_decrypt_core rc4_decrypt_core_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done)
);

// File: tb/rc4_decrypt_core_bench.sv
module rc4_decrypt_core_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [23:0] key = '0;
  logic       ctLoadEn = 1'b0;
  logic [4:0] ctLoadAddr = '0;
  logic [7:0] ctLoadData = '0;
  logic [4:0] ptRdAddr = '0;
  logic [7:0] ptRdData;
  logic       busy, done;

  int total = 0;
  int bad = 0;
  int doneCnt = 0;
  bit finished = 0;

  logic [7:0] ctMem [32];
  logic [7:0] expPt [32];
  logic [7:0] refS  [256];

  always #4 clk = ~clk;

  rc4_decrypt_core u_rc4_decrypt_core (
    .clk(clk), .rstN(rstN), .start(start), .key(key),
    .ctLoadEn(ctLoadEn), .ctLoadAddr(ctLoadAddr), .ctLoadData(ctLoadData),
    .ptRdAddr(ptRdAddr), .ptRdData(ptRdData), .busy(busy), .done(done)
  );

  always @(negedge clk) if (rstN && done) doneCnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent cipher model; key byte 0 = key[23:16]
  task automatic refModel(input logic [23:0] k);
    logic [7:0] kb [3];
    logic [7:0] t, f;
    int j;
    int ii;
    kb[0] = k[23:16]; kb[1] = k[15:8]; kb[2] = k[7:0];
    for (int i = 0; i < 256; i++) refS[i] = 8'(i);
    j = 0;
    for (int i = 0; i < 256; i++) begin
      j = (j + refS[i] + kb[i % 3]) % 256;
      t = refS[i]; refS[i] = refS[j]; refS[j] = t;
    end
    ii = 0; j = 0;
    for (int n = 0; n < 32; n++) begin
      ii = (ii + 1) % 256;
      j = (j + refS[ii]) % 256;
      t = refS[ii]; refS[ii] = refS[j]; refS[j] = t;
      f = refS[(refS[ii] + refS[j]) % 256];
      expPt[n] = f ^ ctMem[n];
    end
  endtask

  task automatic loadCt();
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      ctLoadEn = 1'b1; ctLoadAddr = 5'(a); ctLoadData = ctMem[a];
    end
    @(negedge clk);
    ctLoadEn = 1'b0;
  endtask

  // runs the core; misuse=1 injects a start and a ciphertext write mid-run
  task automatic runCore(input logic [23:0] k, input bit misuse, input string tag);
    int cnt;
    int d0;
    key = k;
    d0 = doneCnt;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", {tag, " busy after start"}, int'(busy), 1);
    cnt = 0;
    while (cnt < 5000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (done) break;
      if (misuse && cnt == 100) begin
        start = 1'b1;
        ctLoadEn = 1'b1; ctLoadAddr = 5'd5; ctLoadData = ~ctMem[5];
      end else if (misuse && cnt == 101) begin
        start = 1'b0;
        ctLoadEn = 1'b0;
      end
      if (misuse && cnt == 1500) start = 1'b1;
      if (misuse && cnt == 1501) start = 1'b0;
    end
    chk(cnt == 2048, "R5", {tag, " done latency"}, cnt, 2048);
    @(negedge clk);
    chk(done == 1'b0, "R5", {tag, " done one cycle"}, int'(done), 0);
    chk(busy == 1'b0, "R9", {tag, " idle after done"}, int'(busy), 0);
    repeat (20) @(negedge clk);
    chk(doneCnt - d0 == 1, "R6", {tag, " single done"}, doneCnt - d0, 1);
    chk(busy == 1'b0, "R6", {tag, " no restart"}, int'(busy), 0);
  endtask

  task automatic readCheck(input string req, input string tag);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      ptRdAddr = 5'(a);
      @(negedge clk);
      chk(ptRdData == expPt[a], req, $sformatf("%s byte %0d", tag, a),
          int'(ptRdData), int'(expPt[a]));
    end
  endtask

  task automatic fullRun(input logic [23:0] k, input bit misuse,
                         input string req, input string tag);
    loadCt();
    refModel(k);
    runCore(k, misuse, tag);
    readCheck(req, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);

    // R4 zero ciphertext exposes the raw keystream, all-zero key
    for (int a = 0; a < 32; a++) ctMem[a] = 8'h00;
    fullRun(24'h000000, 1'b0, "R4", "zero key");

    // R3 byte order: asymmetric keys
    for (int a = 0; a < 32; a++) ctMem[a] = 8'($urandom);
    fullRun(24'h010203, 1'b0, "R3", "key 010203");
    fullRun(24'h030201, 1'b0, "R3", "key 030201");
    fullRun(24'hFFFFFF, 1'b0, "R4", "key FFFFFF");

    // R4 seeded random keys and ciphertexts
    for (int r = 0; r < 3; r++) begin
      for (int a = 0; a < 32; a++) ctMem[a] = 8'($urandom);
      fullRun(24'($urandom), 1'b0, "R4", $sformatf("random %0d", r));
    end

    // R6 R7 start and ciphertext write while busy are ignored
    for (int a = 0; a < 32; a++) ctMem[a] = 8'($urandom);
    fullRun(24'hA5C33C, 1'b1, "R7", "misuse");

    // R2 a repeat of an earlier key after other runs gives the same output
    for (int a = 0; a < 32; a++) ctMem[a] = 8'h00;
    fullRun(24'h000000, 1'b0, "R2", "repeat zero key");

    // R8 plaintext still readable after idle time, reverse order
    repeat (50) @(negedge clk);
    for (int a = 31; a >= 0; a--) begin
      @(negedge clk);
      ptRdAddr = 5'(a);
      @(negedge clk);
      chk(ptRdData == expPt[a], "R8", $sformatf("hold byte %0d", a),
          int'(ptRdData), int'(expPt[a]));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule